// File: doc/BRIEF.md
# Receive Character Queue with Line-Error Tags

This block is the receive buffer of a single serial channel. Each character that the bit-level receiver completes is written into a 512-entry first-in first-out queue together with four error indications: parity, framing, break and overrun. The host takes entries out as 16-bit words. The low byte carries the character and four upper bits carry its flags. A fill counter shows how many entries are waiting.

A 2-bit threshold code and a separate enable bit control a receive request output. The request rises when the fill level reaches the selected threshold, so the host can empty the queue in bursts. A flush input discards everything stored. If a character arrives when no slot is free, it is lost, and the next character that is stored carries an overrun mark.

Control is a four-state machine with the states EMPTY, FILLING, FULL and FLUSHING. The transitions are as follows:
- Any state goes to FLUSHING whenever flush is high.
- FLUSHING goes to EMPTY or FILLING, depending on the next fill level, once flush is low.
- EMPTY goes to FILLING on a stored write.
- FILLING goes to EMPTY when the last entry is read.
- FILLING goes to FULL when the level reaches the depth.
- FULL goes back to FILLING on a read.

Top module: `rxq_fifo`

## Requirements
- R1: After reset the fill count is 0, the read word is 0 and the request is low.
- R2: The read word shows the oldest entry with the character in bits 7:0, parity error in bit 8, overrun in bit 9, framing error in bit 10 and break in bit 11. Bits 15:12 are 0.
- R3: Entries leave in arrival order. The fill count rises by one for each stored write and falls by one for each read of a non-empty queue, one cycle after the strobe. It never exceeds 512.
- R4: A write while the count is 512 is discarded. The next stored entry has bit 9 set even if its own overrun input was low. Later entries do not get that bit unless they are dropped again.
- R5: While the queue is empty the read word is 0, and a read strobe leaves the count at 0.
- R6: The request is high exactly when the count reaches the threshold of the trigger code. Code 1 means 1 or more entries, code 2 means 256 or more and code 3 means 448 or more. The request follows the count in the same cycle.
- R7: Trigger code 0 keeps the request low at any fill level.
- R8: With the request enable low, the request stays low at any fill level and code.
- R9: The count reads 0 in the cycle after flush is high. Writes and reads are ignored while flush is high. A pending overrun mark is cleared. Writes are stored again from the first cycle with flush low.
- R10: With a read and a write in the same cycle, both take effect. When the queue is full at that edge, the write is discarded as in R4 and the count becomes 511.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Character write strobe from the receiver |
| wr_char | input | 8 | Received character |
| wr_parity | input | 1 | Parity error on this character |
| wr_framing | input | 1 | Framing error on this character |
| wr_break | input | 1 | Break condition on this character |
| wr_overrun | input | 1 | Receiver-side overrun on this character |
| rd_en | input | 1 | Host read strobe; removes the oldest entry |
| rd_word | output | 16 | Oldest entry, or 0 when empty |
| fill_count | output | 10 | Number of entries held |
| trig_sel | input | 2 | Request threshold code |
| rx_irq_en | input | 1 | Receive request enable |
| flush | input | 1 | Empty the queue while high |
| rx_req | output | 1 | Receive request |

## Verification
The read word is combinational from the stored head. The bench drives a read on the falling edge and compares the word a short delay later, before the rising edge that removes the entry. The count and the request come from one register stage, so they are due one rising edge after the strobe. The bench compares them one nanosecond after that edge against a queue model that it updates at the same edge. Each flush, threshold and overrun check is sampled at that same point, after the edge that applies the stimulus.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int CHAR_W = 8;
    localparam int FLAG_W = 4;
    localparam int ENTRY_W = CHAR_W + FLAG_W;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_FILLING,
        ST_FULL,
        ST_FLUSHING
    } rxq_state_t;

    typedef struct packed {
        logic              brk;
        logic              framing;
        logic              overrun;
        logic              parity;
        logic [CHAR_W-1:0] data;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       push,
    input  logic       pop,
    input  rxq_entry_t wr_entry,
    output rxq_entry_t head
);
    localparam int AW = $clog2(DEPTH);

    rxq_entry_t      mem [DEPTH];
    logic [AW-1:0]   wptr;
    logic [AW-1:0]   rptr;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
        end
    end

    assign head = mem[rptr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             flush,
    output logic             push,
    output logic             pop,
    output logic             pend_ovr,
    output rxq_state_t       state,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    rxq_state_t       state_n;
    logic [CNT_W-1:0] count_n;
    logic             drop;

    // output decode per state
    always_comb begin
        push = 1'b0;
        pop  = 1'b0;
        drop = 1'b0;
        unique case (state)
            ST_EMPTY, ST_FLUSHING: begin
                push = wr_en && !flush;
            end
            ST_FILLING: begin
                push = wr_en && !flush;
                pop  = rd_en && !flush;
            end
            ST_FULL: begin
                pop  = rd_en && !flush;
                drop = wr_en && !flush;
            end
        endcase
    end

    assign count_n = count + CNT_W'(push) - CNT_W'(pop);

    // next-state decode
    always_comb begin
        state_n = state;
        unique case (state)
            ST_EMPTY, ST_FILLING, ST_FULL, ST_FLUSHING: begin
                if (flush)                  state_n = ST_FLUSHING;
                else if (count_n == '0)     state_n = ST_EMPTY;
                else if (count_n == FULL_LVL) state_n = ST_FULL;
                else                        state_n = ST_FILLING;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_EMPTY;
            count    <= '0;
            pend_ovr <= 1'b0;
        end else begin
            state <= state_n;
            count <= flush ? '0 : count_n;
            if (flush)     pend_ovr <= 1'b0;
            else if (drop) pend_ovr <= 1'b1;
            else if (push) pend_ovr <= 1'b0;
        end
    end
endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger #(
    parameter int DEPTH = 512,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [1:0]       trig_sel,
    input  logic             irq_en,
    input  logic [CNT_W-1:0] count,
    output logic             req
);
    localparam logic [CNT_W-1:0] LVL_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] LVL_HALF = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] LVL_HIGH = CNT_W'((DEPTH * 7) / 8);

    logic hit;

    always_comb begin
        unique case (trig_sel)
            2'd0: hit = 1'b0;
            2'd1: hit = count >= LVL_ONE;
            2'd2: hit = count >= LVL_HALF;
            2'd3: hit = count >= LVL_HIGH;
        endcase
    end

    assign req = irq_en && hit;
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              wr_parity,
    input  logic              wr_framing,
    input  logic              wr_break,
    input  logic              wr_overrun,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_word,
    output logic [CNT_W-1:0]  fill_count,
    input  logic [1:0]        trig_sel,
    input  logic              rx_irq_en,
    input  logic              flush,
    output logic              rx_req
);
    logic       push;
    logic       pop;
    logic       pend_ovr;
    rxq_state_t state;
    rxq_entry_t wr_entry;
    rxq_entry_t head;

    assign wr_entry = '{brk:     wr_break,
                        framing: wr_framing,
                        overrun: wr_overrun | pend_ovr,
                        parity:  wr_parity,
                        data:    wr_char};

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .flush    (flush),
        .push     (push),
        .pop      (pop),
        .pend_ovr (pend_ovr),
        .state    (state),
        .count    (fill_count)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (flush),
        .push     (push),
        .pop      (pop),
        .wr_entry (wr_entry),
        .head     (head)
    );

    rxq_trigger #(.DEPTH(DEPTH)) u_trig (
        .trig_sel (trig_sel),
        .irq_en   (rx_irq_en),
        .count    (fill_count),
        .req      (rx_req)
    );

    assign rd_word = (state == ST_EMPTY || state == ST_FLUSHING)
                     ? '0 : WORD_W'(head);
endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk #(
    parameter int DEPTH = 512,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             flush,
    input logic [1:0]       trig_sel,
    input logic             rx_irq_en,
    input logic [15:0]      rd_word,
    input logic [CNT_W-1:0] fill_count,
    input logic             rx_req
);
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(DEPTH));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !wr_en && !rd_en) |=> $stable(fill_count));

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word[15:12] == 4'h0);

    a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == CNT_W'(DEPTH) && wr_en && !rd_en && !flush)
        |=> fill_count == CNT_W'(DEPTH));

    a_r5_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0) |-> rd_word == 16'h0);

    a_r7_code0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel == 2'd0) |-> !rx_req);

    a_r8_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_irq_en |-> !rx_req);

    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> fill_count == '0);
endmodule

bind rxq_fifo rxq_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .flush      (flush),
    .trig_sel   (trig_sel),
    .rx_irq_en  (rx_irq_en),
    .rd_word    (rd_word),
    .fill_count (fill_count),
    .rx_req     (rx_req)
);

// File: tb/rxq_fifo_tb.sv
`timescale 1ns/1ps
module rxq_fifo_tb;
    localparam int DEPTH = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_char = '0;
    logic        wr_parity = 1'b0;
    logic        wr_framing = 1'b0;
    logic        wr_break = 1'b0;
    logic        wr_overrun = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_word;
    logic [9:0]  fill_count;
    logic [1:0]  trig_sel = 2'd1;
    logic        rx_irq_en = 1'b1;
    logic        flush = 1'b0;
    logic        rx_req;

    int total = 0;
    int fails = 0;
    bit done = 0;
    logic [15:0] model_q [$];
    bit pend = 0;

    always #2.5 clk = ~clk;

    rxq_fifo #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_char(wr_char),
        .wr_parity(wr_parity), .wr_framing(wr_framing), .wr_break(wr_break),
        .wr_overrun(wr_overrun), .rd_en(rd_en), .rd_word(rd_word),
        .fill_count(fill_count), .trig_sel(trig_sel), .rx_irq_en(rx_irq_en),
        .flush(flush), .rx_req(rx_req)
    );

    function automatic int thr(input logic [1:0] code);
        case (code)
            2'd1: thr = 1;
            2'd2: thr = 256;
            2'd3: thr = 448;
            default: thr = DEPTH + 1;
        endcase
    endfunction

    function automatic logic exp_req();
        exp_req = rx_irq_en && (trig_sel != 2'd0) && (model_q.size() >= thr(trig_sel));
    endfunction

    function automatic logic [15:0] exp_head();
        exp_head = (model_q.size() > 0) ? model_q[0] : 16'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock of stimulus: flags = {break, framing, overrun, parity}
    task automatic step(input logic w, input logic [7:0] c, input logic [3:0] fl,
                        input logic r, input logic f);
        logic [15:0] wd;
        bit was_full;
        @(negedge clk);
        wr_en = w; wr_char = c; wr_parity = fl[0]; wr_overrun = fl[1];
        wr_framing = fl[2]; wr_break = fl[3]; rd_en = r; flush = f;
        #0.5;
        if (r) chk("R2 read word", rd_word, exp_head());
        @(posedge clk);
        was_full = (model_q.size() == DEPTH);
        if (f) begin
            model_q.delete();
            pend = 0;
        end else begin
            if (r && model_q.size() > 0) void'(model_q.pop_front());
            if (w && !was_full) begin
                wd = {4'h0, fl[3], fl[2], fl[1] | pend, fl[0], c};
                model_q.push_back(wd);
                pend = 0;
            end else if (w) begin
                pend = 1;
            end
        end
        #1;
        chk("R3 fill count", fill_count, model_q.size());
        chk("R6 request", rx_req, exp_req());
        wr_en = 0; rd_en = 0; flush = 0;
    endtask

    initial begin
        #(1ms);
        if (!done) begin
            fails++; total++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset count", fill_count, 0);
        chk("R1 reset word", rd_word, 0);
        chk("R1 reset request", rx_req, 0);
        @(negedge clk); rst_n = 1'b1;

        // R5: read of empty queue
        step(0, 8'h00, 4'h0, 1, 0);
        chk("R5 empty read count", fill_count, 0);
        chk("R5 empty word", rd_word, 0);

        // R2: flag placement, each flag alone
        step(1, 8'hA5, 4'b0001, 0, 0);
        step(1, 8'h5A, 4'b0010, 0, 0);
        step(1, 8'h3C, 4'b0100, 0, 0);
        step(1, 8'hC3, 4'b1000, 0, 0);
        #1 chk("R2 parity in bit 8", rd_word, 16'h01A5);
        for (int i = 0; i < 4; i++) step(0, 8'h00, 4'h0, 1, 0);

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            logic w, r;
            if (i % 64 == 0) begin
                trig_sel = 2'($urandom_range(0, 3));
                rx_irq_en = ($urandom_range(0, 3) != 0);
            end
            w = ($urandom_range(0, 99) < ((i < 1500) ? 70 : 35));
            r = ($urandom_range(0, 99) < 45);
            step(w, 8'($urandom), 4'($urandom_range(0, 15)), r,
                 ($urandom_range(0, 499) == 0));
        end

        // R9: flush
        step(0, 8'h00, 4'h0, 0, 1);
        for (int i = 0; i < 5; i++) step(1, 8'(i), 4'h0, 0, 0);
        step(1, 8'hEE, 4'h0, 1, 1);
        chk("R9 flush empties", fill_count, 0);
        step(1, 8'hEF, 4'h0, 0, 1);
        chk("R9 write during flush ignored", fill_count, 0);
        step(1, 8'h77, 4'h0, 0, 0);
        chk("R9 write after flush stored", fill_count, 1);
        #1 chk("R9 head after flush", rd_word, 16'h0077);
        step(0, 8'h00, 4'h0, 0, 1);

        // R6: thresholds while filling
        trig_sel = 2'd2; rx_irq_en = 1;
        for (int i = 0; i < 255; i++) step(1, 8'(i), 4'h0, 0, 0);
        chk("R6 code2 below 256", rx_req, 0);
        step(1, 8'hFF, 4'h0, 0, 0);
        chk("R6 code2 at 256", rx_req, 1);
        trig_sel = 2'd3;
        for (int i = 0; i < 191; i++) step(1, 8'(i), 4'h0, 0, 0);
        chk("R6 code3 below 448", rx_req, 0);
        step(1, 8'h11, 4'h0, 0, 0);
        chk("R6 code3 at 448", rx_req, 1);
        trig_sel = 2'd0;
        #1 chk("R7 code0 quiet", rx_req, 0);
        trig_sel = 2'd1; rx_irq_en = 0;
        #1 chk("R8 enable low quiet", rx_req, 0);
        rx_irq_en = 1;

        // R4: fill to capacity, drop, mark next entry
        for (int i = 0; i < 64; i++) step(1, 8'(i + 8'h40), 4'h0, 0, 0);
        chk("R4 full count", fill_count, DEPTH);
        step(1, 8'hD0, 4'h0, 0, 0);
        step(1, 8'hD1, 4'h0, 0, 0);
        chk("R4 drop keeps 512", fill_count, DEPTH);
        step(1, 8'hD2, 4'h0, 1, 0);
        chk("R10 full read+write", fill_count, DEPTH - 1);
        step(1, 8'h99, 4'h0, 0, 0);
        step(0, 8'h00, 4'h0, 1, 0);
        step(1, 8'h9A, 4'h0, 0, 0);
        for (int i = 0; i < DEPTH - 2; i++) step(0, 8'h00, 4'h0, 1, 0);
        #1 chk("R4 overrun mark on next entry", rd_word, 16'h0299);
        step(0, 8'h00, 4'h0, 1, 0);
        #1 chk("R4 later entry unmarked", rd_word, 16'h009A);
        step(0, 8'h00, 4'h0, 1, 0);
        chk("R5 drained", fill_count, 0);

        // R10: simultaneous read and write mid-level
        step(1, 8'h21, 4'h0, 0, 0);
        step(1, 8'h22, 4'h0, 1, 0);
        chk("R10 read+write count", fill_count, 1);
        #1 chk("R10 order kept", rd_word, 16'h0022);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule